// File: doc/BRIEF.md
# Ring-Oscillator Count Thermal Monitor

This block watches one on-die temperature sensor whose oscillator frequency rises with temperature. Once enabled and given a period and a window length, it counts rising edges from the sensor oscillator over a window of reference clocks. It repeats that measurement once every period. Each finished count is compared with three programmable count thresholds, which gives a breach level from 0 to 3. The level then drives escalating hardware actions:

- a DVFS request at level 1 and above;
- a clock-divide throttle request at level 2 and above;
- an emergency reset request at level 3.

Each action has its own enable bit. Software reaches the block through a small 32-bit register bus. It reads the latest count, the level and a valid flag. A single interrupt line reports upward breaches and count saturation, and software clears it by writing the status register back. Converting counts to degrees is left to software.

Top module: `thermcnt_mon`

## Requirements
- R1: After reset the control register reads 0, both threshold registers read all ones in their threshold fields (0xFFFFFFFF at 0x08, 0x0000FFFF at 0x0C), status reads 0, and irq, dvfs_req, throttle_req and reset_req are low.
- R2: The control register at 0x00 reads back what was written. Bit 7 is reserved and always reads 0. The fields are:
  - stop: bit 0
  - throttle enable: bit 1
  - reset enable: bit 2
  - DVFS enable: bit 3
  - saturation interrupt enable: bit 4
  - throttle interrupt enable: bit 5
  - reset interrupt enable: bit 6
  - period P in reference clocks: bits 23:8
  - window W in reference clocks: bits 31:24
- R3: No measurement runs while stop is 1, P is 0 or W is 0. Entering that condition clears the valid flag (status bit 9) within one clock.
- R4: While running, the block counts rising oscillator edges over a window of min(W,P) reference clocks. A new window starts every P clocks. The latest count reads in bits 31:16 of 0x1C.
- R5: The valid flag (status bit 9) stays 0 until the first window after start has finished, then reads 1.
- R6: A count that reaches the all-ones value of the count width saturates there, and the status state field (bits 2:0) then reads 5.
- R7: Threshold fields are placed as follows: threshold 1 in 0x08[15:0], threshold 2 in 0x08[31:16], threshold 3 in 0x0C[15:0]. The level is the highest threshold index whose value is less than or equal to the latest count, or 0 if none is. It changes only when a window finishes, and when the count has not saturated it reads in status bits 2:0.
- R8: The three request outputs follow the level, each gated by its own enable bit:
  - dvfs_req = DVFS enable and level ≥ 1;
  - throttle_req = throttle enable and level ≥ 2;
  - reset_req = reset enable and level = 3.
- R9: At the end of a window the pending flag (status bit 8, also driven on irq) is set when any of these holds:
  - the count saturated and the saturation interrupt is enabled;
  - the level rose from below 2 to 2 or more and the throttle interrupt is enabled;
  - the level rose to 3 and the reset interrupt is enabled.
- R10: A level that stays the same or falls never sets the pending flag.
- R11: Writing 0x18 with bit 8 set clears the pending flag. An event from a window that finishes in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| osc_in | input | 1 | Sensor oscillator, asynchronous |
| irq | output | 1 | Pending interrupt |
| dvfs_req | output | 1 | Passive cooling request |
| throttle_req | output | 1 | Clock-divide throttle request |
| reset_req | output | 1 | Emergency reset request |

## Verification
The assertions assume the following about the inputs:
- osc_in toggles no faster than once per reference clock, so at most one rising edge enters the count per cycle.
- Register writes are single-cycle strobes.
- Thresholds and timing are only changed while the sensor is stopped, or when a new level is acceptable at the next window.

The stimulus keeps within these limits. It drives the oscillator from a generator that toggles every one or more whole clocks, just after the clock edge. Every reprogramming of the thresholds or the timing happens behind a stop write. Because the oscillator phase against the window is not aligned, count checks allow one edge of slack. Level, request and interrupt checks use thresholds placed well away from the nominal count.

// File: rtl/tcm_pkg.sv
// Package: shared register offsets, field layout and state codes of the
// counter-based thermal monitor. Assumes an 8-bit byte address bus.
package tcm_pkg;

    localparam logic [7:0] ADDR_CTRL  = 8'h00;
    localparam logic [7:0] ADDR_THLO  = 8'h08;
    localparam logic [7:0] ADDR_THHI  = 8'h0C;
    localparam logic [7:0] ADDR_STAT  = 8'h18;
    localparam logic [7:0] ADDR_COUNT = 8'h1C;

    localparam logic [2:0] STATE_SAT  = 3'd5;
    localparam int         STAT_PEND  = 8;

    // control register layout, MSB first
    typedef struct packed {
        logic [7:0]  win;
        logic [15:0] per;
        logic        rsvd;
        logic        rst_ie;
        logic        thr_ie;
        logic        sat_ie;
        logic        dvfs_en;
        logic        rst_en;
        logic        thr_en;
        logic        stop;
    } ctrl_t;

endpackage

// File: rtl/tcm_edge_sync.sv
// Module: brings the asynchronous sensor oscillator into the reference
// clock domain with two flops, then emits a one-cycle pulse per rising
// edge. Assumes the oscillator is slower than half the reference clock.
module tcm_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    output logic rise
);
    logic meta_q, sync_q, prev_q;

    // shift the oscillator through the synchronizer and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= osc_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;

endmodule

// File: rtl/tcm_meas.sv
// Module: measurement engine. A period counter runs 0..P-1 while enabled;
// edges are accumulated for the first min(W,P) cycles of each period and
// the saturating result is latched at the last window cycle together with
// a one-cycle done pulse. Assumes run already folds in stop, P!=0, W!=0.
module tcm_meas #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [15:0]   per,
    input  logic [7:0]    win,
    input  logic          rise,
    output logic          done,
    output logic [CW-1:0] count,
    output logic          sat,
    output logic          valid
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    logic [15:0]   pcnt_q, last_w, win16;
    logic [CW-1:0] acc_q, acc_nxt, count_q;
    logic          acc_sat_q, acc_sat_nxt, sat_q, done_q, valid_q;

    // last window cycle: window length clipped to the period
    always_comb begin
        win16  = {8'd0, win};
        last_w = (win16 < per) ? win16 - 16'd1 : per - 16'd1;
    end

    // saturating increment of the accumulator
    always_comb begin
        acc_nxt     = acc_q;
        acc_sat_nxt = acc_sat_q;
        if (rise) begin
            if (acc_q == CMAX) acc_sat_nxt = 1'b1;
            else               acc_nxt     = acc_q + 1'b1;
        end
    end

    // period counter, window accumulation and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt_q    <= '0;
            acc_q     <= '0;
            acc_sat_q <= 1'b0;
            count_q   <= '0;
            sat_q     <= 1'b0;
            done_q    <= 1'b0;
            valid_q   <= 1'b0;
        end else if (!run) begin
            pcnt_q    <= '0;
            acc_q     <= '0;
            acc_sat_q <= 1'b0;
            done_q    <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            pcnt_q <= (pcnt_q >= per - 16'd1) ? 16'd0 : pcnt_q + 16'd1;
            done_q <= 1'b0;
            if (pcnt_q == last_w) begin
                count_q   <= acc_nxt;
                sat_q     <= acc_sat_nxt;
                acc_q     <= '0;
                acc_sat_q <= 1'b0;
                done_q    <= 1'b1;
                valid_q   <= 1'b1;
            end else if (pcnt_q < last_w) begin
                acc_q     <= acc_nxt;
                acc_sat_q <= acc_sat_nxt;
            end
        end
    end

    assign done  = done_q;
    assign count = count_q;
    assign sat   = sat_q;
    assign valid = valid_q;

    AST_SAT_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && sat_q) |-> count_q == CMAX); // R6
    AST_STOP_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !valid_q); // R3
    AST_DONE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(run)); // R4

endmodule

// File: rtl/tcm_level.sv
// Module: compares each finished count with the three thresholds, holds
// the breach level between windows and raises the pending interrupt on
// upward crossings or saturation. Assumes done is a single-cycle pulse.
module tcm_level (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        done,
    input  logic [15:0] count,
    input  logic        sat,
    input  logic [15:0] th1,
    input  logic [15:0] th2,
    input  logic [15:0] th3,
    input  logic        sat_ie,
    input  logic        thr_ie,
    input  logic        rst_ie,
    input  logic        clr,
    output logic [1:0]  level,
    output logic        pend
);
    logic [1:0] lvl_q, new_lvl;
    logic       pend_q, set_evt;

    // highest threshold index not above the count
    always_comb begin
        if      (th3 <= count) new_lvl = 2'd3;
        else if (th2 <= count) new_lvl = 2'd2;
        else if (th1 <= count) new_lvl = 2'd1;
        else                   new_lvl = 2'd0;
    end

    // interrupt events only on saturation or upward crossings
    always_comb begin
        set_evt = done && ((sat && sat_ie)
                        || (thr_ie && new_lvl >= 2'd2 && lvl_q < 2'd2)
                        || (rst_ie && new_lvl == 2'd3 && lvl_q != 2'd3));
    end

    // level register and pending flag, event wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= 2'd0;
            pend_q <= 1'b0;
        end else begin
            if (done)         lvl_q  <= new_lvl;
            if (set_evt)      pend_q <= 1'b1;
            else if (clr)     pend_q <= 1'b0;
        end
    end

    assign level = lvl_q;
    assign pend  = pend_q;

    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(lvl_q)); // R7
    AST_NO_DOWN_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !sat && new_lvl <= lvl_q) |=> !$rose(pend_q)); // R10

endmodule

// File: rtl/thermcnt_mon.sv
// Module: top of the counter-based thermal monitor. Holds the control and
// threshold registers, decodes the register bus, and drives the request
// and interrupt outputs from the breach level. Assumes CNT_W <= 16 and
// single-cycle write strobes; reads are combinational.
module thermcnt_mon #(
    parameter int CNT_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        osc_in,
    output logic        irq,
    output logic        dvfs_req,
    output logic        throttle_req,
    output logic        reset_req
);
    import tcm_pkg::*;

    ctrl_t             ctrl_q;
    logic [31:0]       thlo_q;
    logic [15:0]       th3_q;
    logic              run, rise, m_done, m_sat, m_valid, pend, clr;
    logic [CNT_W-1:0]  m_count;
    logic [15:0]       cnt16;
    logic [1:0]        level;
    logic [2:0]        state;

    // register writes; reserved control bit forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            thlo_q <= 32'hFFFF_FFFF;
            th3_q  <= 16'hFFFF;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_CTRL: begin
                    ctrl_q      <= ctrl_t'(bus_wdata);
                    ctrl_q.rsvd <= 1'b0;
                end
                ADDR_THLO: thlo_q <= bus_wdata;
                ADDR_THHI: th3_q  <= bus_wdata[15:0];
                default: ;
            endcase
        end
    end

    // measurement enable and write-1-to-clear decode
    always_comb begin
        run = !ctrl_q.stop && (ctrl_q.per != 16'd0) && (ctrl_q.win != 8'd0);
        clr = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[STAT_PEND];
    end

    tcm_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .osc_in (osc_in),
        .rise   (rise)
    );

    tcm_meas #(.CW(CNT_W)) u_meas (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .per   (ctrl_q.per),
        .win   (ctrl_q.win),
        .rise  (rise),
        .done  (m_done),
        .count (m_count),
        .sat   (m_sat),
        .valid (m_valid)
    );

    // widen the count to the 16-bit register field
    always_comb begin
        cnt16 = '0;
        cnt16[CNT_W-1:0] = m_count;
    end

    tcm_level u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .done   (m_done),
        .count  (cnt16),
        .sat    (m_sat),
        .th1    (thlo_q[15:0]),
        .th2    (thlo_q[31:16]),
        .th3    (th3_q),
        .sat_ie (ctrl_q.sat_ie),
        .thr_ie (ctrl_q.thr_ie),
        .rst_ie (ctrl_q.rst_ie),
        .clr    (clr),
        .level  (level),
        .pend   (pend)
    );

    // read mux and status state field
    always_comb begin
        state = m_sat ? STATE_SAT : {1'b0, level};
        case (bus_addr)
            ADDR_CTRL:  bus_rdata = ctrl_q;
            ADDR_THLO:  bus_rdata = thlo_q;
            ADDR_THHI:  bus_rdata = {16'd0, th3_q};
            ADDR_STAT:  bus_rdata = {22'd0, m_valid, pend, 5'd0, state};
            ADDR_COUNT: bus_rdata = {cnt16, 16'd0};
            default:    bus_rdata = 32'd0;
        endcase
    end

    // escalating action requests, each behind its enable
    always_comb begin
        irq          = pend;
        dvfs_req     = ctrl_q.dvfs_en && (level != 2'd0);
        throttle_req = ctrl_q.thr_en  && level[1];
        reset_req    = ctrl_q.rst_en  && (level == 2'd3);
    end

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !m_done) |=> !irq); // R11
    AST_RESET_NEEDS_DVFS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_req && ctrl_q.dvfs_en) |-> dvfs_req); // R8

endmodule

// File: tb/thermcnt_mon_tb.sv
module thermcnt_mon_tb;
    localparam int CLK_P = 10;
    localparam int CW    = 6;
    localparam int NVEC  = 6;
    // {half period, W, P, th1, th2, th3, expected level}
    localparam int VEC [NVEC][7] = '{
        '{2,  40,  60, 20, 30, 40, 0},
        '{2,  80, 100, 10, 30, 40, 1},
        '{1,  60,  80, 10, 20, 40, 2},
        '{1, 100, 120, 10, 20, 40, 3},
        '{4,  80,  90,  5,  8,  9, 3},
        '{3,  60, 200,  2, 20, 30, 1}
    };

    logic        clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, osc_in = 1'b0;
    logic [7:0]  bus_addr = 8'd0;
    logic [31:0] bus_wdata = 32'd0, bus_rdata;
    logic        irq, dvfs_req, throttle_req, reset_req;
    int          checks = 0, errors = 0, half = 0;
    logic [31:0] r;

    thermcnt_mon #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .osc_in(osc_in),
        .irq(irq), .dvfs_req(dvfs_req), .throttle_req(throttle_req),
        .reset_req(reset_req)
    );

    always #(CLK_P/2) clk = ~clk;

    // oscillator generator: toggles every 'half' clocks, just after the edge
    initial begin
        forever begin
            if (half == 0) @(posedge clk);
            else begin
                repeat (half) @(posedge clk);
                #1 osc_in = ~osc_in;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    function automatic logic [31:0] cw(input int w, input int p, input logic [7:0] f);
        return {w[7:0], p[15:0], f};
    endfunction

    task automatic finish_sim;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_sim();
    end

    initial begin
        cyc(3);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, r); chk(r == 0, "R1 ctrl", r, 0);
        rd(8'h08, r); chk(r == 32'hFFFF_FFFF, "R1 th12", r, 32'hFFFF_FFFF);
        rd(8'h0C, r); chk(r == 32'h0000_FFFF, "R1 th3", r, 32'hFFFF);
        rd(8'h18, r); chk(r == 0, "R1 status", r, 0);
        chk({irq, dvfs_req, throttle_req, reset_req} == 0, "R1 outputs",
            {irq, dvfs_req, throttle_req, reset_req}, 0);

        // R2 control readback, reserved bit 7 reads zero
        wr(8'h00, 32'hAB12_34FF);
        rd(8'h00, r); chk(r == 32'hAB12_347F, "R2 readback", r, 32'hAB12_347F);

        // R3 period zero: no measurement
        half = 1;
        wr(8'h00, cw(40, 0, 8'h7E));
        cyc(200);
        rd(8'h18, r); chk(r[9] == 0, "R3 no valid with P=0", r[9], 0);

        // R5 valid only after the first window
        wr(8'h00, cw(60, 80, 8'h01));
        wr(8'h00, cw(60, 80, 8'h7E));
        cyc(30);
        rd(8'h18, r); chk(r[9] == 0, "R5 valid before first window", r[9], 0);
        cyc(40);
        rd(8'h18, r); chk(r[9] == 1, "R5 valid after first window", r[9], 1);

        // R4 R7 R8 vector table
        for (int i = 0; i < NVEC; i++) begin
            int e;
            logic [31:0] c, s;
            wr(8'h00, 32'h1);
            wr(8'h08, {VEC[i][4][15:0], VEC[i][3][15:0]});
            wr(8'h0C, {16'd0, VEC[i][5][15:0]});
            half = VEC[i][0];
            wr(8'h00, cw(VEC[i][1], VEC[i][2], 8'h7E));
            cyc(2 * VEC[i][2] + 20);
            rd(8'h1C, c);
            rd(8'h18, s);
            e = VEC[i][1] / (2 * VEC[i][0]);
            chk((int'(c[31:16]) >= e - 1) && (int'(c[31:16]) <= e + 1),
                "R4 count", c[31:16], e);
            chk(s[2:0] == VEC[i][6][2:0], "R7 level", s[2:0], VEC[i][6]);
            chk({dvfs_req, throttle_req, reset_req} ==
                {VEC[i][6] >= 1, VEC[i][6] >= 2, VEC[i][6] == 3},
                "R8 requests", {dvfs_req, throttle_req, reset_req},
                {VEC[i][6] >= 1, VEC[i][6] >= 2, VEC[i][6] == 3});
        end

        // R3 stop clears valid within one clock
        wr(8'h00, cw(60, 200, 8'h7F));
        cyc(1);
        rd(8'h18, r); chk(r[9] == 0, "R3 stop clears valid", r[9], 0);

        // R11 clear pending, then R9 rise to level 2 raises irq
        wr(8'h18, 32'h100);
        rd(8'h18, r); chk(r[8] == 0 && irq == 0, "R11 w1c clears", irq, 0);
        wr(8'h08, {16'd20, 16'd10});
        wr(8'h0C, 32'd40);
        half = 1;
        wr(8'h00, cw(60, 80, 8'h7E));
        cyc(180);
        chk(irq == 1, "R9 irq on rise to level 2", irq, 1);
        // R8 throttle gated by its enable, DVFS still on
        wr(8'h00, cw(60, 80, 8'h7C));
        chk(throttle_req == 0 && dvfs_req == 1, "R8 throttle enable gate",
            {throttle_req, dvfs_req}, 1);
        wr(8'h18, 32'h100);
        cyc(2);
        chk(irq == 0, "R11 irq cleared", irq, 0);

        // R10 level falls without interrupt
        wr(8'h08, {16'd55, 16'd50});
        wr(8'h0C, 32'd60);
        cyc(180);
        rd(8'h18, r); chk(r[2:0] == 0, "R10 level dropped", r[2:0], 0);
        chk(irq == 0, "R10 no irq on fall", irq, 0);
        chk(dvfs_req == 0, "R8 dvfs drops with level", dvfs_req, 0);

        // R6 saturation: 100 edges exceed a 6-bit count
        wr(8'h00, 32'h1);
        wr(8'h08, {16'd20, 16'd10});
        wr(8'h0C, 32'd30);
        wr(8'h00, cw(200, 250, 8'h7E));
        cyc(520);
        rd(8'h1C, r); chk(r[31:16] == 63, "R6 count saturates", r[31:16], 63);
        rd(8'h18, r); chk(r[2:0] == 5, "R6 state reads 5", r[2:0], 5);
        chk(irq == 1, "R9 irq on saturation", irq, 1);
        chk(reset_req == 1, "R8 reset request at saturation", reset_req, 1);

        finish_sim();
    end
endmodule